// File: doc/BRIEF.md
# Hybrid Statistics Counter with Largest-First Flush

This block keeps a bank of packet statistics counters. Each one is split into a narrow fast counter and a wide backing word. An event names one counter, and that counter's narrow part goes up by one in the same cycle, so the block can take one event per clock. The wide words live in an internal array. That array is reached only through a read-modify-write port that is used once every `PERIOD_B` cycles.

A flush controller runs on a fixed cadence. Every `PERIOD_B` cycles it scans the narrow counters and picks the one with the largest value. It hands that value to the backing port and zeroes the chosen narrow counter. The backing port then reads the wide word in one cycle and writes back the sum in the next.

The narrow width only has to hold the most an adversary can pile onto one counter between flushes. That bound grows with the logarithm of `PERIOD_B * N_CTR` divided by the logarithm of `PERIOD_B/(PERIOD_B-1)`. For five counters and a period of five it comes to 4 bits.

A query port returns the true running total of any counter: the wide word plus the narrow value plus any flush still in flight. A flush report (valid, index, amount) shows each selection as it enters the backing port.

Top module: `stat_hybrid_counter`

## Requirements
- R1: While reset is held, and right after it, every query returns 0, and `ovf_sticky` and `fl_valid` are 0.
- R2: An increment with `inc_valid` high adds exactly one to the total of counter `inc_idx`. The query reflects it in the cycle after the clock edge that accepts the increment.
- R3: With `NARROW_W` = 4, `N_CTR` = 5 and `PERIOD_B` = 5, no arrival pattern makes `ovf_sticky` rise.
- R4: An increment that hits a narrow counter at its all-ones value, when that counter is not being flushed in the same cycle, sets `ovf_sticky`. The flag then stays set until reset.
- R5: Counting from 0 after reset, a flush is taken in every cycle k with k mod `PERIOD_B` = `PERIOD_B`-1. `fl_valid` is high for exactly the one cycle after each flush edge and low otherwise.
- R6: The flush picks the narrow counter with the largest value before that cycle's increment. The lowest index wins a tie, including the all-zero case, which reports index 0 and amount 0. `fl_amount` equals the value picked.
- R7: The flushed narrow counter restarts at 0. If an increment names that same counter in the flush cycle, it restarts at 1 instead, so the event is kept.
- R8: The query total stays exact in every cycle, including the two cycles while a flushed amount is in transit to the wide word.
- R9: The backing array sees exactly one read and one write per flush, in consecutive cycles, and no other access. The number of `fl_valid` pulses equals the number of flush periods elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_valid | input | 1 | An event is present this cycle |
| inc_idx | input | IDX_W | Counter index of the event; values of N_CTR or above are ignored |
| qry_idx | input | IDX_W | Counter index to read |
| qry_total | output | WIDE_W | True total of counter `qry_idx` |
| fl_valid | output | 1 | A flush selection entered the backing port last edge |
| fl_idx | output | IDX_W | Index chosen by that flush |
| fl_amount | output | NARROW_W | Narrow value handed to the backing word |
| ovf_sticky | output | 1 | A narrow counter would have wrapped |

## Verification
Several corner cases are driven on purpose. A flush with every counter at zero, and a flush between two equal counters, would show a wrong index from a design that favours the higher index or skips empty flushes. An event that lands on the counter being flushed would drop one count from a design that writes zero unconditionally. Queries aimed at a counter whose amount is still in the read-modify-write pipeline would come back short by that amount if the in-flight term were missing. Long random and adversarial runs, which always feed the runner-up counter, check that four narrow bits never wrap. A second instance built with two bits must raise the sticky flag when one counter is hammered.

// File: rtl/stat_pkg.sv
`timescale 1ns/1ps
package stat_pkg;
    // Defaults: five counters, speed-down of five -> 4 narrow bits suffice
    localparam int unsigned DEF_N_CTR    = 5;
    localparam int unsigned DEF_PERIOD_B = 5;
    localparam int unsigned DEF_NARROW_W = 4;
    localparam int unsigned DEF_WIDE_W   = 64;

    // Backing port read-modify-write sequencing
    typedef enum logic [1:0] {
        RMW_IDLE  = 2'd0,
        RMW_READ  = 2'd1,
        RMW_WRITE = 2'd2
    } rmw_state_e;

    // Width of an index for n entries (at least one bit)
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/stat_phase_timer.sv
`timescale 1ns/1ps
module stat_phase_timer #(
    parameter int unsigned PERIOD_B = stat_pkg::DEF_PERIOD_B
) (
    input  logic clk,
    input  logic rst,
    output logic flush_o
);
    localparam int unsigned PH_W = stat_pkg::idx_width(PERIOD_B);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD_B - 1);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst)                 ph_q <= '0;
        else if (ph_q == PH_LAST) ph_q <= '0;
        else                     ph_q <= ph_q + 1'b1;
    end

    assign flush_o = (ph_q == PH_LAST);

    // Flush strobes never come back to back
    p_flush_gap_r5: assert property (@(posedge clk) disable iff (rst)
        flush_o |=> !flush_o);
endmodule

// File: rtl/stat_argmax_sel.sv
`timescale 1ns/1ps
module stat_argmax_sel #(
    parameter int unsigned N_CTR    = stat_pkg::DEF_N_CTR,
    parameter int unsigned NARROW_W = stat_pkg::DEF_NARROW_W,
    parameter int unsigned IDX_W    = stat_pkg::idx_width(N_CTR)
) (
    input  logic [N_CTR-1:0][NARROW_W-1:0] val_i,
    output logic [IDX_W-1:0]               sel_o,
    output logic [NARROW_W-1:0]            max_o
);
    // Linear scan; a strictly-greater test keeps the lowest index on ties
    always_comb begin
        max_o = val_i[0];
        sel_o = '0;
        for (int i = 1; i < N_CTR; i++) begin
            if (val_i[i] > max_o) begin
                max_o = val_i[i];
                sel_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/stat_backing_rmw.sv
`timescale 1ns/1ps
module stat_backing_rmw #(
    parameter int unsigned N_CTR    = stat_pkg::DEF_N_CTR,
    parameter int unsigned NARROW_W = stat_pkg::DEF_NARROW_W,
    parameter int unsigned WIDE_W   = stat_pkg::DEF_WIDE_W,
    parameter int unsigned IDX_W    = stat_pkg::idx_width(N_CTR)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [NARROW_W-1:0] amt_i,
    input  logic [IDX_W-1:0]    qry_idx_i,
    output logic [WIDE_W-1:0]   qry_wide_o,
    output logic                pend_valid_o,
    output logic                rd_phase_o,
    output logic [IDX_W-1:0]    pend_idx_o,
    output logic [NARROW_W-1:0] pend_amt_o
);
    import stat_pkg::*;

    logic [WIDE_W-1:0]   mem_q [N_CTR];
    rmw_state_e          st_q;
    logic [IDX_W-1:0]    idx_q;
    logic [NARROW_W-1:0] amt_q;
    logic [WIDE_W-1:0]   rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= RMW_IDLE;
            idx_q <= '0;
            amt_q <= '0;
            rd_q  <= '0;
            for (int i = 0; i < N_CTR; i++) mem_q[i] <= '0;
        end else begin
            unique case (st_q)
                RMW_IDLE: if (start_i) begin
                    st_q  <= RMW_READ;
                    idx_q <= idx_i;
                    amt_q <= amt_i;
                end
                RMW_READ: begin
                    rd_q <= mem_q[idx_q];
                    st_q <= RMW_WRITE;
                end
                RMW_WRITE: begin
                    mem_q[idx_q] <= rd_q + WIDE_W'(amt_q);
                    st_q         <= RMW_IDLE;
                end
                default: st_q <= RMW_IDLE;
            endcase
        end
    end

    assign qry_wide_o   = (32'(qry_idx_i) < N_CTR) ? mem_q[qry_idx_i] : '0;
    assign pend_valid_o = (st_q != RMW_IDLE);
    assign rd_phase_o   = (st_q == RMW_READ);
    assign pend_idx_o   = idx_q;
    assign pend_amt_o   = amt_q;

    // One read then one write per flush, and a new flush only when idle
    p_read_then_write_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == RMW_READ) |=> (st_q == RMW_WRITE));
    p_write_then_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == RMW_WRITE) |=> (st_q == RMW_IDLE));
    p_start_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
        start_i |-> (st_q == RMW_IDLE));
endmodule

// File: rtl/stat_hybrid_counter.sv
`timescale 1ns/1ps
module stat_hybrid_counter #(
    parameter int unsigned N_CTR    = stat_pkg::DEF_N_CTR,
    parameter int unsigned PERIOD_B = stat_pkg::DEF_PERIOD_B,
    parameter int unsigned NARROW_W = stat_pkg::DEF_NARROW_W,
    parameter int unsigned WIDE_W   = stat_pkg::DEF_WIDE_W,
    parameter int unsigned IDX_W    = stat_pkg::idx_width(N_CTR)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                inc_valid,
    input  logic [IDX_W-1:0]    inc_idx,
    input  logic [IDX_W-1:0]    qry_idx,
    output logic [WIDE_W-1:0]   qry_total,
    output logic                fl_valid,
    output logic [IDX_W-1:0]    fl_idx,
    output logic [NARROW_W-1:0] fl_amount,
    output logic                ovf_sticky
);
    // PERIOD_B must be at least 3 so the two-cycle backing update ends
    // before the next flush is taken.
    localparam logic [NARROW_W-1:0] NARROW_MAX = '1;

    logic [N_CTR-1:0][NARROW_W-1:0] narrow_q;
    logic                ovf_q;
    logic                flush;
    logic [IDX_W-1:0]    sel_idx;
    logic [NARROW_W-1:0] sel_max;
    logic                inc_ok;
    logic [WIDE_W-1:0]   wide_q;
    logic                pend_valid;
    logic                rd_phase;
    logic [IDX_W-1:0]    pend_idx;
    logic [NARROW_W-1:0] pend_amt;

    assign inc_ok = inc_valid && (32'(inc_idx) < N_CTR);

    stat_phase_timer #(.PERIOD_B(PERIOD_B)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .flush_o (flush)
    );

    stat_argmax_sel #(.N_CTR(N_CTR), .NARROW_W(NARROW_W), .IDX_W(IDX_W)) u_pick (
        .val_i (narrow_q),
        .sel_o (sel_idx),
        .max_o (sel_max)
    );

    stat_backing_rmw #(.N_CTR(N_CTR), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W),
                       .IDX_W(IDX_W)) u_backing (
        .clk          (clk),
        .rst          (rst),
        .start_i      (flush),
        .idx_i        (sel_idx),
        .amt_i        (sel_max),
        .qry_idx_i    (qry_idx),
        .qry_wide_o   (wide_q),
        .pend_valid_o (pend_valid),
        .rd_phase_o   (rd_phase),
        .pend_idx_o   (pend_idx),
        .pend_amt_o   (pend_amt)
    );

    // Narrow counter bank: one increment per cycle, one clear per flush
    always_ff @(posedge clk) begin
        if (rst) begin
            narrow_q <= '0;
            ovf_q    <= 1'b0;
        end else begin
            for (int i = 0; i < N_CTR; i++) begin
                if (flush && (sel_idx == IDX_W'(i))) begin
                    narrow_q[i] <= (inc_ok && inc_idx == IDX_W'(i)) ?
                                   NARROW_W'(1) : '0;
                end else if (inc_ok && inc_idx == IDX_W'(i)) begin
                    narrow_q[i] <= narrow_q[i] + 1'b1;
                    if (narrow_q[i] == NARROW_MAX) ovf_q <= 1'b1;
                end
            end
        end
    end

    // True total: wide word + narrow part + amount still in transit
    always_comb begin
        qry_total = '0;
        if (32'(qry_idx) < N_CTR) begin
            qry_total = wide_q + WIDE_W'(narrow_q[qry_idx]);
            if (pend_valid && pend_idx == qry_idx)
                qry_total = qry_total + WIDE_W'(pend_amt);
        end
    end

    assign fl_valid   = rd_phase;
    assign fl_idx     = pend_idx;
    assign fl_amount  = pend_amt;
    assign ovf_sticky = ovf_q;

    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

    p_clear_after_flush_r7: assert property (@(posedge clk) disable iff (rst)
        (flush && !(inc_ok && inc_idx == sel_idx)) |=> (narrow_q[pend_idx] == '0));

    p_keep_collision_r7: assert property (@(posedge clk) disable iff (rst)
        (flush && inc_ok && inc_idx == sel_idx) |=> (narrow_q[pend_idx] == NARROW_W'(1)));

    generate
        for (genvar g = 0; g < N_CTR; g++) begin : g_pick_chk
            p_pick_is_max_r6: assert property (@(posedge clk) disable iff (rst)
                flush |-> (narrow_q[g] <= sel_max));
            p_pick_lowest_r6: assert property (@(posedge clk) disable iff (rst)
                (flush && (IDX_W'(g) < sel_idx)) |-> (narrow_q[g] < sel_max));
        end
    endgenerate
endmodule

// File: tb/stat_hybrid_counter_tb.sv
`timescale 1ns/1ps
module stat_hybrid_counter_tb_top;
    localparam int N  = 5;
    localparam int B  = 5;
    localparam int NW = 4;
    localparam int WW = 64;
    localparam int IW = 3;

    typedef struct {
        int          qidx;
        logic [63:0] total;
        bit          fv;
        int          fidx;
        int          famt;
    } sb_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inc_valid = 1'b0;
    logic [IW-1:0] inc_idx = '0;
    logic [IW-1:0] qry_idx = '0;
    logic [WW-1:0] qry_total;
    logic fl_valid;
    logic [IW-1:0] fl_idx;
    logic [NW-1:0] fl_amount;
    logic ovf_sticky;

    logic [WW-1:0] sm_total;
    logic sm_fv;
    logic [IW-1:0] sm_fidx;
    logic [1:0] sm_famt;
    logic sm_ovf;

    always #4 clk = ~clk;  // 125 MHz

    stat_hybrid_counter #(.N_CTR(N), .PERIOD_B(B), .NARROW_W(NW), .WIDE_W(WW)) dut_i (
        .clk(clk), .rst(rst), .inc_valid(inc_valid), .inc_idx(inc_idx),
        .qry_idx(qry_idx), .qry_total(qry_total), .fl_valid(fl_valid),
        .fl_idx(fl_idx), .fl_amount(fl_amount), .ovf_sticky(ovf_sticky)
    );

    // Narrow width deliberately too small: must report a wrap
    stat_hybrid_counter #(.N_CTR(N), .PERIOD_B(B), .NARROW_W(2), .WIDE_W(WW)) dut_small (
        .clk(clk), .rst(rst), .inc_valid(inc_valid), .inc_idx(inc_idx),
        .qry_idx(qry_idx), .qry_total(sm_total), .fl_valid(sm_fv),
        .fl_idx(sm_fidx), .fl_amount(sm_famt), .ovf_sticky(sm_ovf)
    );

    int n_checks = 0;
    int n_errors = 0;
    int exp_flushes = 0;
    int seen_flushes = 0;
    int k = 0;
    int last_fidx = 0;
    int model_n [N];
    longint model_t [N];
    sb_item_t sb_q [$];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected result
    task automatic drive(input bit v, input int idx, input int q);
        sb_item_t it;
        int sel;
        @(negedge clk);
        rst = 1'b0;
        inc_valid = v;
        inc_idx = IW'(idx);
        qry_idx = IW'(q);
        it.fv = 1'b0; it.fidx = 0; it.famt = 0;
        if ((k % B) == B - 1) begin
            sel = 0;
            for (int i = 1; i < N; i++) if (model_n[i] > model_n[sel]) sel = i;
            it.fv = 1'b1; it.fidx = sel; it.famt = model_n[sel];
            model_n[sel] = 0;
            last_fidx = sel;
            exp_flushes++;
        end
        if (v) begin
            model_n[idx]++;
            model_t[idx]++;
        end
        it.qidx = q;
        it.total = 64'(model_t[q]);
        sb_q.push_back(it);
        k++;
    endtask

    // Monitor: samples between edges and compares against the queue
    always begin
        sb_item_t it;
        @(posedge clk);
        #2;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            check(qry_total == it.total, "R2 R8 total", longint'(qry_total), longint'(it.total));
            check(fl_valid == it.fv, "R5 flush valid", longint'(fl_valid), longint'(it.fv));
            if (fl_valid) seen_flushes++;
            if (it.fv && fl_valid) begin
                check(int'(fl_idx) == it.fidx, "R6 flush index", longint'(fl_idx), longint'(it.fidx));
                check(int'(fl_amount) == it.famt, "R6 R7 flush amount", longint'(fl_amount), longint'(it.famt));
            end
        end
    end

    function automatic int runner_up();
        int top = 0;
        int sec = -1;
        for (int i = 1; i < N; i++) if (model_n[i] > model_n[top]) top = i;
        for (int i = 0; i < N; i++)
            if (i != top && (sec < 0 || model_n[i] > model_n[sec])) sec = i;
        return sec;
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin model_n[i] = 0; model_t[i] = 0; end
        repeat (2) @(negedge clk);
        // R1: reset state on every index
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            qry_idx = IW'(i);
            #1;
            check(qry_total == 0, "R1 total in reset", longint'(qry_total), 0);
            check(!ovf_sticky && !fl_valid, "R1 flags in reset", longint'({ovf_sticky, fl_valid}), 0);
        end
        // R6: all-zero flush picks index 0 with amount 0
        for (int i = 0; i < B; i++) drive(1'b0, 0, i);
        // R6: tie between 1 and 3 resolves to 1
        drive(1'b1, 1, 1); drive(1'b1, 3, 3); drive(1'b1, 1, 1); drive(1'b1, 3, 3);
        drive(1'b0, 0, 1);
        // R7: collision on the flushed counter keeps the event; R8 query in flight
        drive(1'b1, 2, 2); drive(1'b1, 2, 2); drive(1'b1, 2, 2); drive(1'b1, 2, 2);
        drive(1'b1, 2, 2);
        drive(1'b0, 0, 2); drive(1'b0, 0, 2); drive(1'b1, 2, 2); drive(1'b0, 0, 2);
        drive(1'b0, 0, 2);
        // Random traffic, queries often aimed at the counter in transit
        for (int j = 0; j < 3000; j++) begin
            int q;
            q = ((k % B) <= 1) ? last_fidx : int'($urandom % N);
            drive(($urandom % 8) != 0, int'($urandom % N), q);
        end
        // R3: adversary always feeds the counter that will not be flushed
        for (int j = 0; j < 4000; j++) drive(1'b1, runner_up(), int'($urandom % N));
        for (int j = 0; j < 2000; j++) drive(1'b1, j % N, ((k % B) <= 1) ? last_fidx : j % N);
        check(ovf_sticky == 1'b0, "R3 no wrap before hammer", longint'(ovf_sticky), 0);
        // R4: hammer one counter; small instance must wrap, main must not
        for (int j = 0; j < 40; j++) drive(1'b1, 0, 0);
        for (int j = 0; j < 12; j++) drive(1'b0, 0, j % N);
        @(posedge clk); #3;
        check(ovf_sticky == 1'b0, "R3 legal width never wraps", longint'(ovf_sticky), 0);
        check(sm_ovf == 1'b1, "R4 narrow wrap sets sticky flag", longint'(sm_ovf), 1);
        check(seen_flushes == exp_flushes, "R9 one backing update per period",
              longint'(seen_flushes), longint'(exp_flushes));
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            inc_valid = 1'b0;
            qry_idx = IW'(i);
            #1;
            check(qry_total == 64'(model_t[i]), "R2 R8 final total",
                  longint'(qry_total), model_t[i]);
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", k);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule